// File: doc/BRIEF.md
# Multi-Pin GPIO Register Bank

A register-mapped controller for a bank of general-purpose pins (95 by default). Software reaches it through a plain 32-bit read/write bus with byte addresses. Each pin owns a pair of configuration words at an 8-byte stride. The first word holds the output level, a read-only sampled input level, the interrupt trigger kind and polarity, the direction and a two-bit use select. The second word holds an input-sense disable and a weak-pull choice. Two packed bitmaps sit below the per-pin area. One marks the pins that firmware has released, one bit per pin. The other records interrupt routing for the sixteen pins that support it.

The block drives output enable, output value and pull-up/pull-down controls for every pad. When a pin is in GPIO use, these come from its configuration. In any other use they pass through from the native function. Pad inputs go through a two-flop synchronizer, and a pin reports its input only while its sensing is enabled. Interrupt status and enable registers live elsewhere, so their addresses read as zero here.

The bus read is combinational from the address. A write takes effect at the clock edge on which `bus_we` is sampled high. Bits 1:0 of the address are ignored.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, every pin's first word reads 0x00000004 (input direction, use 0 = native, all other fields 0). Every second word reads 0x00000004 (sensing off, no pull). Ownership words 0x00, 0x04 and 0x08 read 0xFFFFFFFF, 0xFFFFFFFF and 0x7FFFFFFF. The routing word 0x10 reads 0x0000FFFF.
- R2: The first word of pin p is at 0x100 + 8p and holds these fields: bit 31 output level, bit 4 trigger select (1 level), bit 3 trigger invert, bit 2 direction (1 input) and bits 1:0 use select. It reads back what was written, and bits 29:5 read 0.
- R3: The second word of pin p is at 0x104 + 8p. Bit 2 set disables input sensing and bits 1:0 hold the pull code; bits 31:3 read 0.
- R4: Bit 30 of the first word reads the pad input of that pin, taken through two flops: a pad change shows on the second rising edge after it. The bit reads 0 while bit 2 of the second word is 1. Writes to bit 30 have no effect.
- R5: Ownership bit for pin p is bit p%32 of the word at 0x00 + 4*(p/32), and bits beyond the last pin read 0. While that bit is 0, a write to the pin's first word leaves bits 4 and 3 unchanged but still updates the other fields.
- R6: The routing word at 0x10 stores bits 15:0, and its bits 31:16 read 0. Addresses 0x14 and 0x18 read 0.
- R7: With use select 1 (GPIO), pad_oe is the inverse of the direction bit and pad_out is the output level. With any other use select, pad_oe and pad_out follow native_oe and native_out.
- R8: Pull code 2 asserts pad_pu only, code 1 asserts pad_pd only, and codes 0 and 3 assert neither.
- R9: Every other address reads 0 and ignores writes. This includes 0x0C, 0x7C, 0x80, 0x90 and addresses from 0x100 + 8*NPINS upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | NPINS | Raw pad input levels |
| native_out | input | NPINS | Native-function output values |
| native_oe | input | NPINS | Native-function output enables |
| pad_oe | output | NPINS | Pad output enables |
| pad_out | output | NPINS | Pad output values |
| pad_pu | output | NPINS | Weak pull-up enables |
| pad_pd | output | NPINS | Weak pull-down enables |

## Verification
The hardest case to reach is the interplay of three fields. The ownership bitmap gates the trigger fields of a different register, and the sampled input level is visible only through a configuration read whose value also depends on the sense-disable bit of the neighbouring word. Directed steps first clear one ownership bit and write the pin's first word with altered trigger bits. They then toggle the pad with sensing on and off, reading exactly one and two edges after the pad change. A long mixed phase follows: random writes that frequently clear ownership bits, random pad and native activity, and a behavioural model compared on every clock.

// File: rtl/gpio_bank_pkg.sv
// Package: shared field positions, codes, base addresses and the per-pin
// configuration record for the GPIO register bank.
package gpio_bank_pkg;

    localparam int OWN_BASE   = 'h000;
    localparam int ROUTE_BASE = 'h010;
    localparam int CFG_BASE   = 'h100;
    localparam int CFG_STRIDE = 8;

    // First configuration word bit positions
    localparam int B_OUT  = 31;
    localparam int B_IN   = 30;
    localparam int B_TLVL = 4;
    localparam int B_TINV = 3;
    localparam int B_DIR  = 2;

    // Second configuration word bit positions
    localparam int B_SOFF = 2;

    localparam logic [1:0] USE_GPIO = 2'd1;
    localparam logic [1:0] PULL_DN  = 2'd1;
    localparam logic [1:0] PULL_UP  = 2'd2;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic [1:0] use_sel;
        logic       sense_off;
        logic [1:0] pull;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{
        out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0, dir_in: 1'b1,
        use_sel: 2'd0, sense_off: 1'b1, pull: 2'd0
    };

endpackage

// File: rtl/gpio_bank_sync.sv
// Two-flop synchronizer for the pad inputs.
// Assumes the inputs may be asynchronous to clk; resets to zero.
module gpio_bank_sync #(
    parameter int WIDTH = 95
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    // Shift the raw inputs through two register stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/gpio_bank_decode.sv
// Address decoder: classifies a byte address into the ownership bitmap,
// the routing word or a per-pin configuration word. Bits 1:0 are ignored.
// Assumes ADDR_W is wide enough to reach the end of the per-pin area.
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 95,
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 7,
    parameter int OW_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_own,
    output logic              hit_route,
    output logic              hit_cfg,
    output logic              cfg_second,
    output logic [OW_W-1:0]   own_word,
    output logic [IDX_W-1:0]  pin_idx
);

    localparam int OWN_WORDS = (NPINS + 31) / 32;
    localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + NPINS * CFG_STRIDE);
    localparam logic [ADDR_W-1:0] OWN_W0 = ADDR_W'(OWN_BASE / 4);
    localparam logic [ADDR_W-1:0] OWN_WN = ADDR_W'(OWN_BASE / 4 + OWN_WORDS);
    localparam logic [ADDR_W-1:0] RT_W   = ADDR_W'(ROUTE_BASE / 4);

    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] cfg_off;

    // Region classification and index extraction
    always_comb begin
        word_addr  = addr >> 2;
        cfg_off    = addr - CFG_LO;
        hit_own    = (word_addr >= OWN_W0) && (word_addr < OWN_WN);
        hit_route  = (word_addr == RT_W);
        hit_cfg    = (addr >= CFG_LO) && (addr < CFG_HI);
        cfg_second = cfg_off[2];
        own_word   = OW_W'(word_addr - OWN_W0);
        pin_idx    = IDX_W'(cfg_off >> 3);
    end

endmodule

// File: rtl/gpio_bank_pin.sv
// One pin: holds both configuration words, blocks trigger-field writes while
// the pin is reserved for firmware, and muxes pad controls between GPIO and
// native use. Assumes sense_in is already synchronized to clk.
module gpio_bank_pin
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_w1,
    input  logic        wr_w2,
    input  logic [31:0] wdata,
    input  logic        owned,
    input  logic        sense_in,
    input  logic        native_out,
    input  logic        native_oe,
    output logic [31:0] word1,
    output logic [31:0] word2,
    output logic        pad_oe,
    output logic        pad_out,
    output logic        pad_pu,
    output logic        pad_pd
);

    pin_cfg_t cfg;
    logic     gpio_mode;

    // Configuration storage; trigger fields are writable only when released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else begin
            if (wr_w1) begin
                cfg.out_lvl <= wdata[B_OUT];
                cfg.dir_in  <= wdata[B_DIR];
                cfg.use_sel <= wdata[1:0];
                if (owned) begin
                    cfg.trig_lvl <= wdata[B_TLVL];
                    cfg.trig_inv <= wdata[B_TINV];
                end
            end
            if (wr_w2) begin
                cfg.sense_off <= wdata[B_SOFF];
                cfg.pull      <= wdata[1:0];
            end
        end
    end

    // Read-back words assembled from the stored fields and the sampled input
    always_comb begin
        word1         = '0;
        word1[B_OUT]  = cfg.out_lvl;
        word1[B_IN]   = sense_in & ~cfg.sense_off;
        word1[B_TLVL] = cfg.trig_lvl;
        word1[B_TINV] = cfg.trig_inv;
        word1[B_DIR]  = cfg.dir_in;
        word1[1:0]    = cfg.use_sel;
        word2         = '0;
        word2[B_SOFF] = cfg.sense_off;
        word2[1:0]    = cfg.pull;
    end

    // Pad control selection between GPIO and native use
    always_comb begin
        gpio_mode = (cfg.use_sel == USE_GPIO);
        pad_oe    = gpio_mode ? ~cfg.dir_in : native_oe;
        pad_out   = gpio_mode ? cfg.out_lvl : native_out;
        pad_pu    = (cfg.pull == PULL_UP);
        pad_pd    = (cfg.pull == PULL_DN);
    end

endmodule

// File: rtl/gpio_bank.sv
// Top of the GPIO register bank: decoder, input synchronizer, ownership and
// routing bitmaps, one pin cell per pin and the combinational read mux.
// Assumes a single-cycle write strobe and a read that needs no handshake.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS      = 95,
    parameter int ADDR_W     = 12,
    parameter int ROUTE_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    input  logic [NPINS-1:0]  native_out,
    input  logic [NPINS-1:0]  native_oe,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd
);

    localparam int IDX_W     = $clog2(NPINS);
    localparam int SLOTS     = 2 ** IDX_W;
    localparam int OWN_WORDS = (NPINS + 31) / 32;
    localparam int OW_W      = $clog2(OWN_WORDS + 1);

    logic              hit_own, hit_route, hit_cfg, cfg_second;
    logic [OW_W-1:0]   own_word;
    logic [IDX_W-1:0]  pin_idx;
    logic [NPINS-1:0]  pad_sync;
    logic [NPINS-1:0]  own_q;
    logic [ROUTE_BITS-1:0] route_q;
    logic [OWN_WORDS*32-1:0] own_pad;
    logic [31:0]       w1_arr [SLOTS];
    logic [31:0]       w2_arr [SLOTS];

    gpio_bank_decode #(
        .NPINS(NPINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OW_W(OW_W)
    ) u_dec (
        .addr(bus_addr), .hit_own(hit_own), .hit_route(hit_route),
        .hit_cfg(hit_cfg), .cfg_second(cfg_second),
        .own_word(own_word), .pin_idx(pin_idx)
    );

    gpio_bank_sync #(.WIDTH(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
    );

    // Ownership bitmap: one bit per pin, written a 32-bit word at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '1;
        end else if (bus_we && hit_own) begin
            for (int i = 0; i < NPINS; i++) begin
                if (int'(own_word) == i / 32) own_q[i] <= bus_wdata[i % 32];
            end
        end
    end

    // Routing bitmap: only the low ROUTE_BITS bits exist
    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= '1;
        else if (bus_we && hit_route) route_q <= bus_wdata[ROUTE_BITS-1:0];
    end

    // One cell per pin; unused index slots read as zero
    for (genvar p = 0; p < SLOTS; p++) begin : g_pin
        if (p < NPINS) begin : g_real
            gpio_bank_pin u_pin (
                .clk(clk), .rst_n(rst_n),
                .wr_w1(bus_we && hit_cfg && !cfg_second && pin_idx == IDX_W'(p)),
                .wr_w2(bus_we && hit_cfg &&  cfg_second && pin_idx == IDX_W'(p)),
                .wdata(bus_wdata), .owned(own_q[p]), .sense_in(pad_sync[p]),
                .native_out(native_out[p]), .native_oe(native_oe[p]),
                .word1(w1_arr[p]), .word2(w2_arr[p]),
                .pad_oe(pad_oe[p]), .pad_out(pad_out[p]),
                .pad_pu(pad_pu[p]), .pad_pd(pad_pd[p])
            );
        end else begin : g_none
            assign w1_arr[p] = '0;
            assign w2_arr[p] = '0;
        end
    end

    // Read mux over the mapped regions; everything else reads zero
    always_comb begin
        own_pad            = '0;
        own_pad[NPINS-1:0] = own_q;
        bus_rdata          = '0;
        if (hit_own)
            bus_rdata = own_pad[int'(own_word)*32 +: 32];
        else if (hit_route)
            bus_rdata[ROUTE_BITS-1:0] = route_q;
        else if (hit_cfg)
            bus_rdata = cfg_second ? w2_arr[pin_idx] : w1_arr[pin_idx];
    end

endmodule

// File: rtl/gpio_bank_chk.sv
// Checker for the GPIO register bank, bound to every gpio_bank instance.
// Observes only the top-level ports.
module gpio_bank_chk #(
    parameter int NPINS  = 95,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pad_pd
);

    localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'('h100);
    localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'('h100 + NPINS * 8);

    // R9
    unmapped_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'('h14) && bus_addr < CFG_LO) |-> bus_rdata == 32'd0);

    // R9
    unmapped_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= CFG_HI) |-> bus_rdata == 32'd0);

    // R6
    route_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:2] == ADDR_W'('h10 >> 2)) |-> bus_rdata[31:16] == 16'd0);

    // R2
    word1_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= CFG_LO && bus_addr < CFG_HI && !bus_addr[2]) |-> bus_rdata[29:5] == 25'd0);

    // R3
    word2_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= CFG_LO && bus_addr < CFG_HI && bus_addr[2]) |-> bus_rdata[31:3] == 29'd0);

    // R8
    pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/gpio_bank_test.sv
// Bench for gpio_bank: directed steps per requirement plus a random phase,
// with a behavioural model compared on every clock.
module gpio_bank_test;

    localparam int N  = 95;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0, native_out = '0, native_oe = '0;
    logic [N-1:0]  pad_oe, pad_out, pad_pu, pad_pd;

    int checks = 0;
    int failures = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .native_out(native_out), .native_oe(native_oe), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    always #5 clk = ~clk;

    // Behavioural reference state
    bit     m_own [N];
    int     m_route;
    bit     m_out [N], m_tl [N], m_ti [N], m_dir [N], m_off [N];
    int     m_use [N], m_pull [N];
    bit     m_s1 [N], m_s2 [N];

    function automatic logic [31:0] mread(int a);
        logic [31:0] r = '0;
        int p;
        if (a < 'h0C) begin
            for (int b = 0; b < 32; b++)
                if ((a / 4) * 32 + b < N) r[b] = m_own[(a / 4) * 32 + b];
        end else if (a >= 'h10 && a < 'h14) begin
            r = m_route;
        end else if (a >= 'h100 && a < 'h100 + N * 8) begin
            p = (a - 'h100) / 8;
            if (((a / 4) % 2) == 0) begin
                r[31] = m_out[p]; r[30] = m_s2[p] && !m_off[p];
                r[4] = m_tl[p]; r[3] = m_ti[p]; r[2] = m_dir[p];
                r[1:0] = 2'(m_use[p]);
            end else begin
                r[2] = m_off[p]; r[1:0] = 2'(m_pull[p]);
            end
        end
        return r;
    endfunction

    function automatic void mwrite(int a, logic [31:0] d);
        int p;
        if (a < 'h0C) begin
            for (int b = 0; b < 32; b++)
                if ((a / 4) * 32 + b < N) m_own[(a / 4) * 32 + b] = d[b];
        end else if (a >= 'h10 && a < 'h14) begin
            m_route = int'(d[15:0]);
        end else if (a >= 'h100 && a < 'h100 + N * 8) begin
            p = (a - 'h100) / 8;
            if (((a / 4) % 2) == 0) begin
                m_out[p] = d[31]; m_dir[p] = d[2]; m_use[p] = int'(d[1:0]);
                if (m_own[p]) begin m_tl[p] = d[4]; m_ti[p] = d[3]; end
            end else begin
                m_off[p] = d[2]; m_pull[p] = int'(d[1:0]);
            end
        end
    endfunction

    // Model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_route = 'hFFFF;
            for (int p = 0; p < N; p++) begin
                m_own[p] = 1; m_out[p] = 0; m_tl[p] = 0; m_ti[p] = 0;
                m_dir[p] = 1; m_use[p] = 0; m_off[p] = 1; m_pull[p] = 0;
                m_s1[p] = 0; m_s2[p] = 0;
            end
        end else begin
            if (bus_we) mwrite(int'(bus_addr), bus_wdata);
            for (int p = 0; p < N; p++) begin
                m_s2[p] = m_s1[p];
                m_s1[p] = pad_in[p];
            end
        end
    end

    function automatic string region_tag(int a);
        if (a < 'h0C) return "R5";
        if (a >= 'h10 && a < 'h14) return "R6";
        if (a >= 'h100 && a < 'h100 + N * 8) return ((a / 4) % 2 == 0) ? "R2" : "R3";
        return "R9";
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, 3 ns after the rising edge
    always @(posedge clk) begin
        #3;
        if (live && rst_n) begin
            logic [N-1:0] eoe, eout, epu, epd;
            for (int p = 0; p < N; p++) begin
                eoe[p]  = (m_use[p] == 1) ? !m_dir[p] : native_oe[p];
                eout[p] = (m_use[p] == 1) ? m_out[p] : native_out[p];
                epu[p]  = (m_pull[p] == 2);
                epd[p]  = (m_pull[p] == 1);
            end
            check(region_tag(int'(bus_addr)), bus_rdata, mread(int'(bus_addr)));
            checks++;
            if (pad_oe !== eoe || pad_out !== eout) begin
                failures++;
                $display("FAIL R7 oe=%h/%h out=%h/%h", pad_oe, eoe, pad_out, eout);
            end
            checks++;
            if (pad_pu !== epu || pad_pd !== epd) begin
                failures++;
                $display("FAIL R8 pu=%h/%h pd=%h/%h", pad_pu, epu, pad_pd, epd);
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, int a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = AW'(a);
        #2 check(tag, bus_rdata, exp);
    endtask

    task automatic bit_chk(string tag, logic got, logic exp);
        check(tag, 32'(got), 32'(exp));
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;

        // R1 reset state
        rd_chk("R1", 'h100, 32'h0000_0004);
        rd_chk("R1", 'h104, 32'h0000_0004);
        rd_chk("R1", 'h3F0, 32'h0000_0004);
        rd_chk("R1", 'h000, 32'hFFFF_FFFF);
        rd_chk("R1", 'h004, 32'hFFFF_FFFF);
        rd_chk("R1", 'h008, 32'h7FFF_FFFF);
        rd_chk("R1", 'h010, 32'h0000_FFFF);

        // R2 field readback, R7 GPIO pad control on pin 5
        wr('h128, 32'h8000_001D);
        rd_chk("R2", 'h128, 32'h8000_001D);
        bit_chk("R7 gpio input oe", pad_oe[5], 1'b0);
        wr('h128, 32'h8000_0019);
        #2 bit_chk("R7 gpio output oe", pad_oe[5], 1'b1);
        bit_chk("R7 gpio output high", pad_out[5], 1'b1);
        wr('h128, 32'h0000_0019);
        #2 bit_chk("R7 gpio output low", pad_out[5], 1'b0);

        // R7 native pass-through
        native_out[5] = 1'b1; native_oe[5] = 1'b0;
        wr('h128, 32'h8000_0018);
        #2 bit_chk("R7 native oe0", pad_oe[5], 1'b0);
        bit_chk("R7 native out", pad_out[5], 1'b1);
        @(negedge clk) native_oe[5] = 1'b1; native_out[5] = 1'b0;
        #1 bit_chk("R7 native oe1", pad_oe[5], 1'b1);
        bit_chk("R7 native out0", pad_out[5], 1'b0);

        // R3 / R8 second word and pulls
        wr('h12C, 32'hFFFF_FFFA);
        rd_chk("R3", 'h12C, 32'h0000_0002);
        bit_chk("R8 pull-up", pad_pu[5], 1'b1);
        bit_chk("R8 no pull-down", pad_pd[5], 1'b0);
        wr('h12C, 32'h0000_0001);
        #2 bit_chk("R8 pull-down", pad_pd[5], 1'b1);
        wr('h12C, 32'h0000_0003);
        rd_chk("R3", 'h12C, 32'h0000_0003);
        bit_chk("R8 code3 pu", pad_pu[5], 1'b0);
        bit_chk("R8 code3 pd", pad_pd[5], 1'b0);
        wr('h12C, 32'h0000_0000);

        // R4 two-edge input sampling
        @(negedge clk);
        bus_addr = AW'('h128); pad_in[5] = 1'b1;
        #2 check("R4 before edge", bus_rdata, 32'h8000_0018);
        @(posedge clk); #2 check("R4 after one edge", bus_rdata, 32'h8000_0018);
        @(posedge clk); #2 check("R4 after two edges", bus_rdata, 32'hC000_0018);
        @(negedge clk) pad_in[5] = 1'b0;
        repeat (3) @(posedge clk);
        wr('h128, 32'hC000_0018);
        rd_chk("R4 write to input bit ignored", 'h128, 32'h8000_0018);
        @(negedge clk) pad_in[5] = 1'b1;
        repeat (3) @(posedge clk);
        rd_chk("R4 sensing on", 'h128, 32'hC000_0018);
        wr('h12C, 32'h0000_0004);
        rd_chk("R4 sensing off", 'h128, 32'h8000_0018);

        // R5 ownership gating of trigger fields
        wr('h000, 32'hFFFF_FFDF);
        rd_chk("R5", 'h000, 32'hFFFF_FFDF);
        wr('h128, 32'h0000_0005);
        rd_chk("R5 trigger kept when reserved", 'h128, 32'h0000_001D);
        wr('h130, 32'h0000_0015);
        rd_chk("R5 released neighbour", 'h130, 32'h0000_0015);
        wr('h000, 32'hFFFF_FFFF);
        wr('h128, 32'h0000_0005);
        rd_chk("R5 trigger written when released", 'h128, 32'h0000_0005);
        wr('h008, 32'h0000_0000);
        rd_chk("R5", 'h008, 32'h0000_0000);
        wr('h008, 32'hFFFF_FFFF);
        rd_chk("R5 last word top bit", 'h008, 32'h7FFF_FFFF);

        // R6 routing word
        wr('h010, 32'h1234_5678);
        rd_chk("R6", 'h010, 32'h0000_5678);
        rd_chk("R6", 'h014, 32'h0000_0000);
        rd_chk("R6", 'h018, 32'h0000_0000);

        // R9 unmapped addresses
        wr('h080, 32'hFFFF_FFFF);
        wr('h090, 32'hFFFF_FFFF);
        wr('h07C, 32'hFFFF_FFFF);
        wr('h00C, 32'hFFFF_FFFF);
        wr('h3F8, 32'hFFFF_FFFF);
        rd_chk("R9", 'h080, 32'h0);
        rd_chk("R9", 'h07C, 32'h0);
        rd_chk("R9", 'h00C, 32'h0);
        rd_chk("R9", 'h3F8, 32'h0);
        rd_chk("R9 no side effect", 'h3F0, 32'h0000_0004);
        rd_chk("R9 no side effect", 'h000, 32'hFFFF_FFFF);

        // Mixed random phase, checked by the per-clock model comparison
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            case ($urandom_range(0, 5))
                0:       bus_addr = AW'($urandom_range(0, 3) * 4);
                1:       bus_addr = AW'($urandom_range(0, 'h3F) * 4);
                default: bus_addr = AW'('h100 + $urandom_range(0, N * 2 + 3) * 4);
            endcase
            bus_we    = ($urandom_range(0, 2) == 0);
            bus_wdata = $urandom;
            if ($urandom_range(0, 3) == 0) pad_in[$urandom_range(0, N - 1)] ^= 1'b1;
            if ($urandom_range(0, 3) == 0) native_oe[$urandom_range(0, N - 1)] ^= 1'b1;
            if ($urandom_range(0, 3) == 0) native_out[$urandom_range(0, N - 1)] ^= 1'b1;
        end
        @(negedge clk) bus_we = 1'b0;
        repeat (3) @(posedge clk);
        #4;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule